// File: doc/BRIEF.md
# Branch delay slot tracker

This block follows the retired instruction stream of a processor with delayed control transfers. It works out, one instruction at a time, whether each instruction occupies the slot that follows a delayed branch or jump. Each retiring instruction arrives with a valid strobe, its program counter and two decoded attribute bits. The first bit marks the instruction as a delayed control transfer. The second marks it as forbidden in a delay slot.

The block keeps a register holding the PC of the most recently retired instruction. It also exposes the slot status of that instruction, so that a downstream exception unit can use it. A forbidden instruction that lands in a slot raises a one-cycle error pulse. The offending PC is captured alongside the pulse and held until the next error. A configuration input turns delay slots off. While it is set, a delayed transfer opens no slot.

Top module: `dslot_tracker`

## Requirements
- R1: After synchronous reset, `in_slot`, `viol_pulse`, `prev_pc` and `viol_pc` are all zero, and no slot is pending.
- R2: A valid instruction with `rt_dcti`=1 while `cfg_no_slot`=0 puts the next valid instruction in a delay slot. One cycle after that next instruction's valid cycle, `in_slot` reads 1. The stream never places a delayed transfer in a slot itself; this is checked by assertion only.
- R3: A pending slot is consumed by exactly one instruction. The valid instruction after the slot instruction reads `in_slot`=0, unless the slot instruction itself was a delayed transfer.
- R4: One cycle after each valid cycle, `prev_pc` equals that cycle's `rt_pc`.
- R5: Cycles with `rt_valid`=0 change no output and no state. A pending slot survives any number of idle cycles.
- R6: A valid instruction with `rt_no_slot`=1 that occupies a slot gives `viol_pulse`=1 for exactly the following cycle, with `viol_pc` equal to its PC.
- R7: A valid instruction with `rt_no_slot`=1 outside a slot raises no error.
- R8: `viol_pc` holds its value until the next error pulse.
- R9: `cfg_no_slot`, sampled in the delayed transfer's own valid cycle, stops that transfer from opening a slot. The next instruction then reads `in_slot`=0 and raises no error.
- R10: Delayed transfers and their slot instructions retired in consecutive cycles each resolve correctly, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_slot | input | 1 | 1 = delayed transfers open no delay slot |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_pc | input | PC_W | PC of the retiring instruction |
| rt_dcti | input | 1 | Retiring instruction is a delayed control transfer |
| rt_no_slot | input | 1 | Retiring instruction is forbidden in a delay slot |
| in_slot | output | 1 | The last retired instruction occupied a delay slot |
| prev_pc | output | PC_W | PC of the last retired instruction |
| viol_pulse | output | 1 | One-cycle error: forbidden instruction found in a slot |
| viol_pc | output | PC_W | PC of the most recent offending instruction |

## Verification
The bench builds the block with its default PC_W of 32. This lets PCs near the top of the address space, such as 0xFFFFFFFC, flow through both the previous-PC register and the error capture register, so a truncated PC path would show. With the default width, the gaps between slot openers and slot users, the switching of the disable input and back-to-back transfer pairs are all driven at full PC precision.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    localparam int unsigned DEF_PC_W = 32;

    typedef struct packed {
        logic dcti;
        logic no_slot;
    } insn_attr_t;

    typedef struct packed {
        logic pend;
        logic cur;
    } slot_state_t;

    function automatic logic opens_slot(input insn_attr_t a, input logic cfg_off);
        return a.dcti && !cfg_off;
    endfunction

    function automatic logic is_violation(input insn_attr_t a, input logic in_slot_now);
        return a.no_slot && in_slot_now;
    endfunction

endpackage

// File: rtl/dslot_flag_pipe.sv
module dslot_flag_pipe
    import dslot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       cfg_off,
    input  insn_attr_t attr,
    output logic       pend_now,
    output logic       cur_flag
);

    slot_state_t st_q;
    slot_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.cur  = st_q.pend;
            st_d.pend = opens_slot(attr, cfg_off);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_now = st_q.pend;
    assign cur_flag = st_q.cur;

endmodule

// File: rtl/dslot_viol_capture.sv
module dslot_viol_capture
    import dslot_pkg::*;
#(
    parameter int unsigned PC_W = DEF_PC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  insn_attr_t      attr,
    input  logic            slot_now,
    input  logic [PC_W-1:0] pc,
    output logic            err_pulse,
    output logic [PC_W-1:0] err_pc
);

    logic hit;
    assign hit = adv && is_violation(attr, slot_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse <= 1'b0;
            err_pc    <= '0;
        end else begin
            err_pulse <= hit;
            if (hit) err_pc <= pc;
        end
    end

endmodule

// File: rtl/dslot_prev_pc.sv
module dslot_prev_pc #(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] ppc
);

    always_ff @(posedge clk) begin
        if (rst)      ppc <= '0;
        else if (adv) ppc <= pc;
    end

endmodule

// File: rtl/dslot_tracker.sv
module dslot_tracker
    import dslot_pkg::*;
#(
    parameter int unsigned PC_W = DEF_PC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_no_slot,
    input  logic            rt_valid,
    input  logic [PC_W-1:0] rt_pc,
    input  logic            rt_dcti,
    input  logic            rt_no_slot,
    output logic            in_slot,
    output logic [PC_W-1:0] prev_pc,
    output logic            viol_pulse,
    output logic [PC_W-1:0] viol_pc
);

    insn_attr_t attr;
    logic       pend_slot;

    assign attr.dcti    = rt_dcti;
    assign attr.no_slot = rt_no_slot;

    dslot_flag_pipe u_flags (
        .clk      (clk),
        .rst      (rst),
        .adv      (rt_valid),
        .cfg_off  (cfg_no_slot),
        .attr     (attr),
        .pend_now (pend_slot),
        .cur_flag (in_slot)
    );

    dslot_viol_capture #(.PC_W(PC_W)) u_viol (
        .clk       (clk),
        .rst       (rst),
        .adv       (rt_valid),
        .attr      (attr),
        .slot_now  (pend_slot),
        .pc        (rt_pc),
        .err_pulse (viol_pulse),
        .err_pc    (viol_pc)
    );

    dslot_prev_pc #(.PC_W(PC_W)) u_ppc (
        .clk (clk),
        .rst (rst),
        .adv (rt_valid),
        .pc  (rt_pc),
        .ppc (prev_pc)
    );

endmodule

// File: rtl/dslot_tracker_chk.sv
module dslot_tracker_chk #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_no_slot,
    input logic            rt_valid,
    input logic [PC_W-1:0] rt_pc,
    input logic            rt_dcti,
    input logic            in_slot,
    input logic [PC_W-1:0] prev_pc,
    input logic            viol_pulse,
    input logic [PC_W-1:0] viol_pc,
    input logic            pend_slot
);

    assert_no_cti_in_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (rt_valid && pend_slot) |-> !rt_dcti);

    assert_prev_pc_follows_R4: assert property (@(posedge clk) disable iff (rst)
        rt_valid |=> (prev_pc == $past(rt_pc)));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !rt_valid |=> ($stable(prev_pc) && $stable(in_slot) && $stable(pend_slot)));

    assert_viol_in_slot_R6: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> in_slot);

    assert_viol_pc_held_R8: assert property (@(posedge clk) disable iff (rst)
        !viol_pulse |=> ($stable(viol_pc) || viol_pulse));

    assert_cfg_off_no_pend_R9: assert property (@(posedge clk) disable iff (rst)
        (rt_valid && cfg_no_slot) |=> !pend_slot);

endmodule

bind dslot_tracker dslot_tracker_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_no_slot (cfg_no_slot),
    .rt_valid    (rt_valid),
    .rt_pc       (rt_pc),
    .rt_dcti     (rt_dcti),
    .in_slot     (in_slot),
    .prev_pc     (prev_pc),
    .viol_pulse  (viol_pulse),
    .viol_pc     (viol_pc),
    .pend_slot   (pend_slot)
);

// File: tb/dslot_tracker_bench.sv
module dslot_tracker_bench;

    localparam int unsigned PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_no_slot = 1'b0;
    logic            rt_valid = 1'b0;
    logic [PC_W-1:0] rt_pc = '0;
    logic            rt_dcti = 1'b0;
    logic            rt_no_slot = 1'b0;
    logic            in_slot;
    logic [PC_W-1:0] prev_pc;
    logic            viol_pulse;
    logic [PC_W-1:0] viol_pc;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dslot_tracker #(.PC_W(PC_W)) u_dslot_tracker (
        .clk(clk), .rst(rst), .cfg_no_slot(cfg_no_slot),
        .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_dcti(rt_dcti), .rt_no_slot(rt_no_slot),
        .in_slot(in_slot), .prev_pc(prev_pc), .viol_pulse(viol_pulse), .viol_pc(viol_pc)
    );

    task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic retire(input logic [PC_W-1:0] pc, input logic dcti, input logic nos);
        rt_valid = 1'b1; rt_pc = pc; rt_dcti = dcti; rt_no_slot = nos;
        @(posedge clk); #1;
        rt_valid = 1'b0; rt_dcti = 1'b0; rt_no_slot = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        chk("R1 in_slot", in_slot, 0);
        chk("R1 viol_pulse", viol_pulse, 0);
        chk("R1 prev_pc", prev_pc, 0);
        chk("R1 viol_pc", viol_pc, 0);
        retire(32'h10, 1'b0, 1'b1);
        chk("R1 no pending slot after reset", viol_pulse, 0);
    endtask

    task automatic t_basic;
        retire(32'h100, 1'b1, 1'b0);
        chk("R4 prev_pc", prev_pc, 32'h100);
        chk("R2 transfer itself not in slot", in_slot, 0);
        retire(32'h104, 1'b0, 1'b0);
        chk("R2 slot flagged", in_slot, 1);
        chk("R4 prev_pc", prev_pc, 32'h104);
        retire(32'h108, 1'b0, 1'b0);
        chk("R3 slot consumed", in_slot, 0);
    endtask

    task automatic t_gap_violation;
        retire(32'h200, 1'b1, 1'b0);
        idle(5);
        chk("R5 prev_pc held over idle", prev_pc, 32'h200);
        chk("R5 in_slot held over idle", in_slot, 0);
        retire(32'h204, 1'b0, 1'b1);
        chk("R5 pending survives idle", in_slot, 1);
        chk("R6 pulse", viol_pulse, 1);
        chk("R6 pc", viol_pc, 32'h204);
        idle(1);
        chk("R6 pulse one cycle", viol_pulse, 0);
        chk("R8 pc held", viol_pc, 32'h204);
    endtask

    task automatic t_outside;
        retire(32'h300, 1'b0, 1'b1);
        chk("R7 no pulse outside slot", viol_pulse, 0);
        chk("R8 pc held after non-error", viol_pc, 32'h204);
    endtask

    task automatic t_cfg;
        cfg_no_slot = 1'b1;
        retire(32'h400, 1'b1, 1'b0);
        cfg_no_slot = 1'b0;
        retire(32'h404, 1'b0, 1'b1);
        chk("R9 no slot when disabled", in_slot, 0);
        chk("R9 no error when disabled", viol_pulse, 0);
        retire(32'h408, 1'b1, 1'b0);
        cfg_no_slot = 1'b1;
        retire(32'h40C, 1'b0, 1'b0);
        chk("R9 config sampled at transfer", in_slot, 1);
        cfg_no_slot = 1'b0;
    endtask

    task automatic t_back_to_back;
        retire(32'h500, 1'b1, 1'b0);
        retire(32'h504, 1'b0, 1'b0);
        chk("R10 first slot", in_slot, 1);
        retire(32'h508, 1'b1, 1'b0);
        chk("R10 transfer after slot", in_slot, 0);
        retire(32'hFFFF_FFFC, 1'b0, 1'b1);
        chk("R10 second slot", in_slot, 1);
        chk("R10 pulse", viol_pulse, 1);
        chk("R6 full-width pc", viol_pc, 32'hFFFF_FFFC);
        chk("R4 full-width prev_pc", prev_pc, 32'hFFFF_FFFC);
        retire(32'h510, 1'b0, 1'b0);
        chk("R3 cleared after slot", in_slot, 0);
        chk("R6 pulse dropped", viol_pulse, 0);
        chk("R8 pc kept", viol_pc, 32'hFFFF_FFFC);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_gap_violation();
        t_outside();
        t_cfg();
        t_back_to_back();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule